// File: doc/BRIEF.md
# External Interrupt Input Unit

This block sits between up to six external interrupt pins and the chip's interrupt controller. Each pin crosses into the core clock domain through a two-flop synchroniser. A per-input sensitivity code then selects the event to watch for: a rising edge, a falling edge, either edge, a high level or a low level. A detected event sets a pending bit. The block raises one request line per input while that input's pending bit and enable bit are both set.

Software reaches the block over a small 32-bit register bus. One word holds the six 4-bit sensitivity codes. A second word holds the pending bits, and a bit is cleared by writing zero to it. A third word holds the enable bits. A parameter can leave the upper half of the inputs out of the hardware. Those inputs then read as zero and never raise a request.

Top module: `xirq_unit`

## Requirements
- R1: After a synchronous reset, every sensitivity code, pending bit and enable bit is zero, every request is low and `bus_rdata` is zero.
- R2: Register map, using byte offsets on `bus_addr`. The sensitivity word is at 0x0, with input i in bits [4i+3:4i]. The pending word is at 0x4 and the enable word is at 0xC, with input i in bit i of each. Any other offset reads zero. Read data appears on `bus_rdata` after the clock edge that samples the read, and it holds until the next read.
- R3: Code 0x1 detects rising edges, 0x2 falling edges and 0x3 both edges. If a pin changes before clock edge k, the pending bit and the request rise after edge k+2. An edge of the opposite sense sets nothing.
- R4: A pending bit set by an edge stays set until software writes 0 to that bit at offset 0x4. Writing 1 to a bit there has no effect.
- R5: Code 0x5 (high level) and code 0x6 (low level) make the pending bit follow the synchronised pin level while the input is enabled. In these modes a write of 0 to the pending bit does not keep it clear.
- R6: Code 0x0 and every code not listed above detect nothing. A pending bit that is already set keeps its value until software clears it.
- R7: The request for input i equals pending AND enable. While the enable bit is 0, pin activity sets no pending bit. Clearing the enable bit drops the request after the write edge, and an edge-mode pending bit survives this.
- R8: With `FULL_SET` = 0, only inputs 0 to 2 exist. Sensitivity, pending and enable bits for inputs 3 to 5 read as zero and ignore writes, and requests 3 to 5 stay low.
- R9: When an edge event and a pending-clear write reach an edge-mode input at the same clock edge, the event wins and the pending bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_o | output | NUM_PINS | Request per input toward the interrupt controller |

## Verification
The assertions check the following on every cycle:
- an edge-mode pending bit survives any cycle that has no clear write for it;
- a level-mode pending bit equals the synchronised level of the previous cycle;
- a disabled input, or an input with code 0, never gains a pending bit;
- read data for the enable word is returned one cycle late;
- reset clears the outputs.

Some properties depend on the pins' history and are shown only by the bench scenarios:
- the exact three-edge latency from a pin change to its request;
- the rejection of an edge of the opposite sense;
- the event winning over a clear written in the same cycle;
- the absence of the upper inputs in the reduced build.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam logic [3:0] OFF_SENS = 4'h0;
  localparam logic [3:0] OFF_PEND = 4'h4;
  localparam logic [3:0] OFF_EN   = 4'hC;

  typedef enum logic [3:0] {
    SENS_OFF  = 4'h0,
    SENS_RISE = 4'h1,
    SENS_FALL = 4'h2,
    SENS_BOTH = 4'h3,
    SENS_HIGH = 4'h5,
    SENS_LOW  = 4'h6
  } sens_e;

  function automatic logic is_edge_code(input logic [3:0] code);
    return (code == SENS_RISE) || (code == SENS_FALL) || (code == SENS_BOTH);
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, stab_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
      last_q <= stab_q;
    end
  end

  assign cur_o  = stab_q;
  assign prev_o = last_q;
endmodule

// File: rtl/xirq_lane.sv
module xirq_lane
  import xirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] code_i,
  input  logic       cur_i,
  input  logic       prev_i,
  input  logic       en_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic pend_q, pend_d, ev;

  always_comb begin
    unique case (code_i)
      SENS_RISE: ev = cur_i & ~prev_i;
      SENS_FALL: ev = ~cur_i & prev_i;
      SENS_BOTH: ev = cur_i ^ prev_i;
      default:   ev = 1'b0;
    endcase
    if (is_edge_code(code_i))
      pend_d = (pend_q & ~clr_i) | (en_i & ev);
    else if (code_i == SENS_HIGH)
      pend_d = en_i & cur_i;
    else if (code_i == SENS_LOW)
      pend_d = en_i & ~cur_i;
    else
      pend_d = pend_q & ~clr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int NUM_LIVE = 6,
  parameter int DW       = 32,
  parameter int AW       = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  input  logic [NUM_PINS-1:0]   pend_i,
  output logic [4*NUM_PINS-1:0] sens_o,
  output logic [NUM_PINS-1:0]   en_o,
  output logic [NUM_PINS-1:0]   clr_o,
  output logic [DW-1:0]         rdata_o
);
  localparam int SW = 4 * NUM_PINS;

  logic wr_sens, wr_pend, wr_en, rd;
  logic [DW-1:0] rdata_q;
  logic unused_hi;

  assign wr_sens = bus_sel & bus_wr & (bus_addr == AW'(OFF_SENS));
  assign wr_pend = bus_sel & bus_wr & (bus_addr == AW'(OFF_PEND));
  assign wr_en   = bus_sel & bus_wr & (bus_addr == AW'(OFF_EN));
  assign rd      = bus_sel & ~bus_wr;
  assign unused_hi = ^bus_wdata[DW-1:SW];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_field
    assign clr_o[i] = wr_pend & ~bus_wdata[i];
    if (i < NUM_LIVE) begin : g_live
      logic [3:0] sens_q;
      logic       en_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sens_q <= '0;
          en_q   <= 1'b0;
        end else begin
          if (wr_sens) sens_q <= bus_wdata[4*i +: 4];
          if (wr_en)   en_q   <= bus_wdata[i];
        end
      end
      assign sens_o[4*i +: 4] = sens_q;
      assign en_o[i]          = en_q;
    end else begin : g_absent
      assign sens_o[4*i +: 4] = '0;
      assign en_o[i]          = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd) begin
      case (bus_addr)
        AW'(OFF_SENS): rdata_q <= DW'(sens_o);
        AW'(OFF_PEND): rdata_q <= DW'(pend_i);
        AW'(OFF_EN):   rdata_q <= DW'(en_o);
        default:       rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter bit FULL_SET = 1'b1,
  parameter int DW       = 32,
  parameter int AW       = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic [NUM_PINS-1:0] irq_o
);
  localparam int NUM_LIVE = FULL_SET ? NUM_PINS : NUM_PINS / 2;

  logic [4*NUM_PINS-1:0] cfg_q;
  logic [NUM_PINS-1:0]   en_q, pend_q, clr, sync_cur, sync_prev;

  xirq_sync #(.W(NUM_LIVE)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_i[NUM_LIVE-1:0]),
    .cur_o   (sync_cur[NUM_LIVE-1:0]),
    .prev_o  (sync_prev[NUM_LIVE-1:0])
  );

  xirq_regs #(.NUM_PINS(NUM_PINS), .NUM_LIVE(NUM_LIVE), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_i    (pend_q),
    .sens_o    (cfg_q),
    .en_o      (en_q),
    .clr_o     (clr),
    .rdata_o   (bus_rdata)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_in
    if (i < NUM_LIVE) begin : g_lane
      xirq_lane u_lane (
        .clk    (clk),
        .rst    (rst),
        .code_i (cfg_q[4*i +: 4]),
        .cur_i  (sync_cur[i]),
        .prev_i (sync_prev[i]),
        .en_i   (en_q[i]),
        .clr_i  (clr[i]),
        .pend_o (pend_q[i])
      );
    end else begin : g_none
      assign pend_q[i]    = 1'b0;
      assign sync_cur[i]  = 1'b0;
      assign sync_prev[i] = 1'b0;
    end
  end

  assign irq_o = pend_q & en_q;
endmodule

// File: rtl/xirq_unit_chk.sv
module xirq_unit_chk
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int NUM_LIVE = 6,
  parameter int DW       = 32,
  parameter int AW       = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [AW-1:0]         bus_addr,
  input logic [DW-1:0]         bus_wdata,
  input logic [DW-1:0]         bus_rdata,
  input logic [NUM_PINS-1:0]   irq_o,
  input logic [4*NUM_PINS-1:0] cfg_q,
  input logic [NUM_PINS-1:0]   en_q,
  input logic [NUM_PINS-1:0]   pend_q,
  input logic [NUM_PINS-1:0]   sync_cur
);
  logic wr_pend;
  assign wr_pend = bus_sel && bus_wr && (bus_addr == AW'(OFF_PEND));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && bus_rdata == '0));

  p_en_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == AW'(OFF_EN))
      |=> bus_rdata == {{(DW-NUM_PINS){1'b0}}, $past(en_q)});

  for (genvar i = 0; i < NUM_LIVE; i++) begin : g_pin
    p_edge_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && is_edge_code(cfg_q[4*i +: 4]) && !(wr_pend && !bus_wdata[i]))
        |=> pend_q[i]);

    p_level_high_r5: assert property (@(posedge clk) disable iff (rst)
      (en_q[i] && cfg_q[4*i +: 4] == SENS_HIGH) |=> pend_q[i] == $past(sync_cur[i]));

    p_level_low_r5: assert property (@(posedge clk) disable iff (rst)
      (en_q[i] && cfg_q[4*i +: 4] == SENS_LOW) |=> pend_q[i] == !$past(sync_cur[i]));

    p_code_off_r6: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[4*i +: 4] == SENS_OFF && !pend_q[i]) |=> !pend_q[i]);

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      (!en_q[i] && !pend_q[i]) |=> !pend_q[i]);
  end

  if (NUM_LIVE < NUM_PINS) begin : g_half
    p_absent_low_r8: assert property (@(posedge clk) disable iff (rst)
      irq_o[NUM_PINS-1:NUM_LIVE] == '0);
  end
endmodule

bind xirq_unit xirq_unit_chk #(
  .NUM_PINS(NUM_PINS), .NUM_LIVE(NUM_LIVE), .DW(DW), .AW(AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .cfg_q     (cfg_q),
  .en_q      (en_q),
  .pend_q    (pend_q),
  .sync_cur  (sync_cur)
);

// File: tb/xirq_unit_tb.sv
`timescale 1ns/1ps
module xirq_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  pin = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_h;
  logic [5:0]  irq, irq_h;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xirq_unit u_dut (.clk(clk), .rst(rst), .pin_i(pin), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));
  xirq_unit #(.FULL_SET(1'b0)) u_half (.clk(clk), .rst(rst), .pin_i(pin), .bus_sel(sel),
    .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_h), .irq_o(irq_h));

  // Behavioural reference model of the full instance.
  int m_cfg, m_pend, m_en, m_rd;
  bit [5:0] m_s1, m_s2, m_pv;
  always @(posedge clk) begin
    int np;
    if (rst) begin
      m_cfg = 0; m_pend = 0; m_en = 0; m_rd = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
    end else begin
      np = 0;
      if (sel && !wr)
        m_rd = (addr == 0) ? m_cfg : (addr == 4) ? m_pend : (addr == 12) ? m_en : 0;
      for (int i = 0; i < 6; i++) begin
        int code; bit c, e, p, ev, cu, pv;
        code = (m_cfg >> (4*i)) & 15;
        c  = sel && wr && addr == 4 && !wdata[i];
        e  = m_en[i]; p = m_pend[i]; cu = m_s2[i]; pv = m_pv[i];
        ev = (code == 1) ? (cu && !pv) : (code == 2) ? (!cu && pv) :
             (code == 3) ? (cu != pv) : 1'b0;
        if (code >= 1 && code <= 3) p = (p && !c) || (e && ev);
        else if (code == 5) p = e && cu;
        else if (code == 6) p = e && !cu;
        else p = p && !c;
        np[i] = p;
      end
      if (sel && wr && addr == 0)  m_cfg = wdata & 32'h00FF_FFFF;
      if (sel && wr && addr == 12) m_en  = wdata & 32'h3F;
      m_pend = np; m_pv = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [5:0] ex;
      ex = 6'(m_pend & m_en);
      checks++;
      if (irq !== ex) begin
        errors++;
        $display("FAIL R7 model irq actual=%h expected=%h", irq, ex);
      end
      checks++;
      if (rdata !== m_rd) begin
        errors++;
        $display("FAIL R2 model rdata actual=%h expected=%h", rdata, m_rd);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d, output logic [31:0] dh);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    d = rdata; dh = rdata_h;
    sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, dh;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    bus_read(4'h0, d, dh); chk("R1 sens", d, 0);
    bus_read(4'h4, d, dh); chk("R1 pend", d, 0);
    bus_read(4'hC, d, dh); chk("R1 en", d, 0);
    // R2 map: rise, fall, both, high, low, off
    bus_write(4'h0, 32'h0006_5321);
    bus_read(4'h0, d, dh); chk("R2 sens readback", d, 32'h0006_5321);
    bus_read(4'h8, d, dh); chk("R2 unused offset", d, 0);
    // R7 disabled inputs ignore pins
    pin = 6'b000111; tick(4); pin = 6'b000000; tick(4);
    bus_read(4'h4, d, dh); chk("R7 disabled no pend", d, 0);
    bus_write(4'hC, 32'h3F);
    tick(3);
    bus_read(4'h4, d, dh); chk("R5 low level pend", d, 32'h10);
    chk("R5 low level irq", 32'(irq), 32'h10);
    // R3 rising latency
    pin[0] = 1'b1;
    tick(2); chk("R3 rise not yet", 32'(irq[0]), 0);
    tick(1); chk("R3 rise after third edge", 32'(irq[0]), 1);
    // R3 falling ignores rise
    pin[1] = 1'b1; tick(4); chk("R3 fall ignores rise", 32'(irq[1]), 0);
    pin[1] = 1'b0; tick(4); chk("R3 fall detected", 32'(irq[1]), 1);
    // R3 both edges, R4 clear by zero
    pin[2] = 1'b1; tick(4);
    bus_read(4'h4, d, dh); chk("R3 both rise", d, 32'h17);
    bus_write(4'h4, 32'hFFFF_FFFB);
    bus_read(4'h4, d, dh); chk("R4 clear one bit", d, 32'h13);
    pin[2] = 1'b0; tick(4);
    bus_read(4'h4, d, dh); chk("R3 both fall", d, 32'h17);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, d, dh); chk("R4 write one no effect", d, 32'h17);
    // R5 high level follows pin
    pin[3] = 1'b1; tick(4); chk("R5 high active", 32'(irq[3]), 1);
    pin[3] = 1'b0; tick(4); chk("R5 high released", 32'(irq[3]), 0);
    bus_write(4'h4, 32'h0);
    bus_read(4'h4, d, dh); chk("R5 level ignores clear", d, 32'h10);
    // R6 code off detects nothing, holds existing pending
    pin[5] = 1'b1; tick(4); pin[5] = 1'b0; tick(4);
    bus_read(4'h4, d, dh); chk("R6 off no detect", d, 32'h10);
    pin[0] = 1'b0; tick(4); pin[0] = 1'b1; tick(4);
    bus_write(4'h0, 32'h0006_5320);
    tick(2);
    bus_read(4'h4, d, dh); chk("R6 off holds pending", d, 32'h11);
    // R7 enable gating
    bus_write(4'hC, 32'h3E); chk("R7 disable drops irq", 32'(irq), 32'h10);
    bus_write(4'hC, 32'h00); chk("R7 all disabled", 32'(irq), 0);
    tick(2);
    bus_read(4'h4, d, dh); chk("R7 edge pend survives", d, 32'h01);
    // R9 event and clear in the same edge
    bus_write(4'h0, 32'h0006_5321);
    bus_write(4'h4, 32'h0);
    bus_write(4'hC, 32'h04);
    pin[2] = 1'b1;
    tick(2);
    bus_write(4'h4, 32'h0);
    chk("R9 event wins over clear", 32'(irq), 32'h04);
    // Random phase, checked by the model each cycle
    for (int k = 0; k < 400; k++) begin
      pin = 6'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        sel = 1'b1; wr = 1'($urandom); addr = 4'($urandom_range(0, 3) * 4); wdata = $urandom;
      end else sel = 1'b0;
      tick(1);
    end
    sel = 1'b0; wr = 1'b0;
    // R8 reduced build
    rst = 1'b1; tick(2); rst = 1'b0; pin = '0; tick(1);
    bus_write(4'h0, 32'h0055_5555);
    bus_write(4'hC, 32'h3F);
    pin = 6'h3F; tick(4);
    chk("R8 half irq", 32'(irq_h), 32'h07);
    chk("R8 full irq", 32'(irq), 32'h3F);
    bus_read(4'h0, d, dh);
    chk("R8 full sens", d, 32'h0055_5555);
    chk("R8 half sens", dh, 32'h0000_0555);
    bus_read(4'hC, d, dh); chk("R8 half en", dh, 32'h07);
    bus_read(4'h4, d, dh); chk("R8 half pend", dh, 32'h07);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule